// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counter with a small word-addressed register port. Software programs a reload value, picks a counting mode and a clock divider, and then enables it. The counter steps once for every one, sixteen or two hundred fifty-six pulses of an input tick enable. Each time it steps from one to zero it raises an interrupt flag, which stays set until software writes the clear register. Whether that flag reaches the interrupt pin depends on an enable bit.

There are three modes. Periodic mode reloads the programmed value after zero. One-shot mode halts at zero. Free-running mode ignores the programmed value and wraps at the full counter width. The counter can run as 32 bits or as 16 bits. There are two ways to write the reload value. One also restarts the count at once. The other only changes the value used at the next natural reload.

The bus port is a plain valid, write, word-address and data set. A write takes effect at the clock edge where valid is high. Read data is combinational from the address while valid is high with write low, and it is 0 otherwise.

Top module: `interval_timer`

## Requirements
- R1: Word index 0 is Load, 1 is the current count (read-only, writes have no effect), 2 is Control, 3 is interrupt clear (write-only), 4 is raw flag, 5 is masked flag and 6 is deferred load. Reads of index 0 and index 6 return the same stored reload value.
- R2: Control bits are: 0 one-shot, 1 wide (32-bit), 3:2 divider, 5 interrupt enable, 6 periodic and 7 run. Divider code 00 steps on every tick enable, 01 on every 16th and 10 or 11 on every 256th. The divider count restarts when Control is written.
- R3: With periodic and one-shot both clear, the counter reloads with 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, and the Load value is ignored, including when Load is written.
- R4: In periodic or one-shot mode a write to index 0 stores the value and puts it into the counter at the same edge.
- R5: A write to index 6 stores the reload value and leaves the running count untouched until the next natural reload.
- R6: A step from one to zero sets the raw flag (bit 0 of index 4). Writing any value to index 3 clears it.
- R7: The interrupt output is high exactly when the raw flag and the interrupt enable bit are both set. Index 5 reads 0 whenever interrupt enable is clear.
- R8: After reset Control reads 0x20, Load reads 0, the raw flag is clear, and the count reads 0xFFFF.
- R9: In one-shot mode the counter stays at zero after reaching it. In periodic and free-running modes a step from zero loads the reload value.
- R10: Word index 7 reads as 0, and writes to it change no register.
- R11: While the run bit is clear, tick enables do not change the count.
- R12: In 16-bit mode only the low 16 bits count and are tested for zero, and reads of the count return 0 in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-rate enable pulse into the divider |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 3 | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the timer with the default 32-bit counter, a 3-bit word index and divider taps of 16 and 256. At these values every mode, both widths and all divider settings can be reached with a few hundred tick pulses. The bench drives tickEn by hand, one pulse at a time. This makes it possible to check the exact step at which the count reaches zero, wraps or reloads, and the exact tick at which a restarted divider first fires. With a 3-bit index the unmapped word 7 can also be reached.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  localparam int IDX_LOAD  = 0;
  localparam int IDX_VALUE = 1;
  localparam int IDX_CTRL  = 2;
  localparam int IDX_CLEAR = 3;
  localparam int IDX_RAW   = 4;
  localparam int IDX_MASK  = 5;
  localparam int IDX_BGLD  = 6;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  // Control register fields, MSB first (bit 7 .. bit 0)
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       intEn;
    logic       spare;
    logic [1:0] preSel;
    logic       wide;
    logic       oneShot;
  } ctrlReg_t;

  // Strobes and mode bits from control to datapath
  typedef struct packed {
    logic       run;
    logic       oneShot;
    logic       wide;
    logic [1:0] preSel;
    logic       loadNow;
    logic       preRestart;
  } dpCmd_t;

endpackage

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  countVis,
  input  logic              zeroHit,
  output dpCmd_t            dpCmd,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [7:0]        ctrlBits,
  output logic              rawFlag,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] FULL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HALF_ONES = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  ctrlReg_t         ctrlQ;
  logic [CNT_W-1:0] loadQ;
  logic             flagQ;

  logic wrLoad, wrCtrl, wrClear, wrBg, rdEn, freeMode;
  logic [CNT_W-1:0] srcLoad;

  assign wrLoad  = busValid && busWrite && (busAddr == ADDR_W'(IDX_LOAD));
  assign wrCtrl  = busValid && busWrite && (busAddr == ADDR_W'(IDX_CTRL));
  assign wrClear = busValid && busWrite && (busAddr == ADDR_W'(IDX_CLEAR));
  assign wrBg    = busValid && busWrite && (busAddr == ADDR_W'(IDX_BGLD));
  assign rdEn    = busValid && !busWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= ctrlReg_t'(CTRL_RESET);
      loadQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= ctrlReg_t'(busWdata[7:0]);
      if (wrLoad || wrBg) loadQ <= busWdata;
      // a zero event in the same cycle as a clear wins
      if (zeroHit) flagQ <= 1'b1;
      else if (wrClear) flagQ <= 1'b0;
    end
  end

  assign freeMode = !ctrlQ.periodic && !ctrlQ.oneShot;
  assign srcLoad  = (wrLoad || wrBg) ? busWdata : loadQ;

  always_comb begin
    if (freeMode) reloadVal = ctrlQ.wide ? FULL_ONES : HALF_ONES;
    else          reloadVal = srcLoad;
  end

  always_comb begin
    dpCmd.run        = ctrlQ.run;
    dpCmd.oneShot    = ctrlQ.oneShot;
    dpCmd.wide       = ctrlQ.wide;
    dpCmd.preSel     = ctrlQ.preSel;
    dpCmd.loadNow    = wrLoad;
    dpCmd.preRestart = wrCtrl;
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (int'(busAddr))
        IDX_LOAD, IDX_BGLD: busRdata = loadQ;
        IDX_VALUE:          busRdata = countVis;
        IDX_CTRL:           busRdata = {{(CNT_W-8){1'b0}}, ctrlQ};
        IDX_RAW:            busRdata = {{(CNT_W-1){1'b0}}, flagQ};
        IDX_MASK:           busRdata = {{(CNT_W-1){1'b0}}, flagQ && ctrlQ.intEn};
        default:            busRdata = '0;
      endcase
    end
  end

  assign ctrlBits = ctrlQ;
  assign rawFlag  = flagQ;
  assign irqOut   = flagQ && ctrlQ.intEn;

endmodule

// File: rtl/itimer_datapath.sv
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRE_A_W = 4,
  parameter int PRE_B_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpCmd_t           dpCmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countVis,
  output logic             zeroHit
);

  localparam int HALF_W = CNT_W / 2;

  logic [PRE_B_W-1:0] preCnt;
  logic               preTick, step, atZero, atOne;
  logic [CNT_W-1:0]   countQ, countDec;

  // divider: free-running on tickEn, restarted on a Control write
  always_ff @(posedge clk) begin
    if (!rstN || dpCmd.preRestart) preCnt <= '0;
    else if (tickEn)               preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    case (dpCmd.preSel)
      2'b00:   preTick = tickEn;
      2'b01:   preTick = tickEn && (&preCnt[PRE_A_W-1:0]);
      default: preTick = tickEn && (&preCnt);
    endcase
  end

  assign step = dpCmd.run && preTick;

  generate
    if (CNT_W > 1) begin : g_split
      always_comb begin
        if (dpCmd.wide) begin
          atZero   = (countQ == '0);
          atOne    = (countQ == CNT_W'(1));
          countDec = countQ - 1'b1;
        end else begin
          atZero   = (countQ[HALF_W-1:0] == '0);
          atOne    = (countQ[HALF_W-1:0] == HALF_W'(1));
          countDec = {countQ[CNT_W-1:HALF_W], countQ[HALF_W-1:0] - 1'b1};
        end
      end
    end else begin : g_single
      always_comb begin
        atZero   = (countQ == '0);
        atOne    = (countQ != '0);
        countDec = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '1;
    end else if (dpCmd.loadNow) begin
      countQ <= reloadVal;
    end else if (step) begin
      if (atZero) begin
        if (!dpCmd.oneShot) countQ <= reloadVal;
      end else begin
        countQ <= countDec;
      end
    end
  end

  assign zeroHit  = step && !dpCmd.loadNow && atOne;
  assign countVis = dpCmd.wide ? countQ
                               : {{(CNT_W-HALF_W){1'b0}}, countQ[HALF_W-1:0]};

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int PRE_A_W = 4,
  parameter int PRE_B_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);

  dpCmd_t           dpCmd;
  logic [CNT_W-1:0] reloadVal, countVis;
  logic [7:0]       ctrlBits;
  logic             zeroHit, rawFlag;

  itimer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .countVis(countVis),
    .zeroHit(zeroHit), .dpCmd(dpCmd), .reloadVal(reloadVal),
    .ctrlBits(ctrlBits), .rawFlag(rawFlag), .busRdata(busRdata),
    .irqOut(irqOut)
  );

  itimer_datapath #(.CNT_W(CNT_W), .PRE_A_W(PRE_A_W), .PRE_B_W(PRE_B_W)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dpCmd(dpCmd),
    .reloadVal(reloadVal), .countVis(countVis), .zeroHit(zeroHit)
  );

endmodule

// File: rtl/interval_timer_checker.sv
module interval_timer_checker #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  busWdata,
  input logic              irqOut,
  input logic [7:0]        ctrlBits,
  input logic              rawFlag,
  input logic [CNT_W-1:0]  countVis
);

  logic anyWr;
  assign anyWr = busValid && busWrite;

  a_r1_value_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    anyWr && busAddr == ADDR_W'(1) && !tickEn |=> $stable(countVis));

  a_r5_bg_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    anyWr && busAddr == ADDR_W'(6) && !tickEn |=> $stable(countVis));

  a_r4_load_immediate: assert property (@(posedge clk) disable iff (!rstN)
    anyWr && busAddr == ADDR_W'(0) && ctrlBits[1] && (ctrlBits[6] || ctrlBits[0])
    |=> countVis == $past(busWdata));

  a_r6_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
    anyWr && busAddr == ADDR_W'(3) && !tickEn |=> !rawFlag);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ctrlBits[5] && rawFlag));

  a_r9_oneshot_holds: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[0] && ctrlBits[7] && countVis == '0 && !anyWr |=> countVis == '0);

  a_r11_idle_no_count: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[7] && !anyWr |=> $stable(countVis));

endmodule

bind interval_timer interval_timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busValid(busValid),
  .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .irqOut(irqOut), .ctrlBits(ctrlBits), .rawFlag(rawFlag), .countVis(countVis)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  interval_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 3'(idx); busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input int idx, input logic [31:0] exp);
    logic [31:0] got;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 3'(idx);
    #1 got = busRdata;
    busValid = 1'b0;
    check(tag, got, exp);
  endtask

  task automatic irqCheck(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {31'b0, irqOut}, {31'b0, exp});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic testReset();
    rdCheck("R8 ctrl", 2, 32'h20);
    rdCheck("R8 load", 0, 32'h0);
    rdCheck("R8 count", 1, 32'hFFFF);
    rdCheck("R8 raw", 4, 32'h0);
    irqCheck("R8 irq", 1'b0);
  endtask

  task automatic testReadOnlyAndUnmapped();
    wr(1, 32'h1234);
    rdCheck("R1 value write ignored", 1, 32'hFFFF);
    rdCheck("R10 unmapped read", 7, 32'h0);
    wr(7, 32'hFF);
    rdCheck("R10 ctrl untouched", 2, 32'h20);
    rdCheck("R10 load untouched", 0, 32'h0);
  endtask

  task automatic testPeriodic();
    wr(2, 32'h42);
    wr(0, 5);
    rdCheck("R4 load immediate", 1, 5);
    ticks(3);
    rdCheck("R11 no count when idle", 1, 5);
    wr(2, 32'hE2);
    ticks(4);
    rdCheck("R6 one step before zero", 1, 1);
    rdCheck("R6 raw clear before zero", 4, 0);
    ticks(1);
    rdCheck("R6 reached zero", 1, 0);
    rdCheck("R6 raw set", 4, 1);
    rdCheck("R7 masked set", 5, 1);
    irqCheck("R7 irq high", 1'b1);
    ticks(1);
    rdCheck("R9 periodic reload", 1, 5);
    wr(3, 32'hDEAD);
    rdCheck("R6 clear", 4, 0);
    irqCheck("R7 irq low after clear", 1'b0);
  endtask

  task automatic testBackground();
    wr(6, 9);
    rdCheck("R5 count untouched", 1, 5);
    rdCheck("R1 load reads bg value", 0, 9);
    ticks(5);
    rdCheck("R5 old period finishes", 1, 0);
    ticks(1);
    rdCheck("R5 new value at reload", 1, 9);
    wr(3, 0);
  endtask

  task automatic testMask();
    wr(2, 32'hC2);
    ticks(9);
    rdCheck("R7 raw set unmasked", 4, 1);
    rdCheck("R7 masked reads 0", 5, 0);
    irqCheck("R7 irq low when disabled", 1'b0);
    wr(3, 0);
  endtask

  task automatic testOneShot();
    wr(2, 32'h83);
    wr(0, 2);
    rdCheck("R4 load oneshot", 1, 2);
    ticks(2);
    rdCheck("R9 oneshot zero", 1, 0);
    rdCheck("R6 oneshot flag", 4, 1);
    ticks(3);
    rdCheck("R9 oneshot holds", 1, 0);
    wr(3, 0);
  endtask

  task automatic testNarrow();
    wr(2, 32'h40);
    wr(0, 32'h0001_0002);
    rdCheck("R12 upper bits hidden", 1, 32'h2);
    wr(2, 32'hC0);
    ticks(2);
    rdCheck("R12 low half zero", 1, 0);
    rdCheck("R12 flag on low zero", 4, 1);
    ticks(1);
    rdCheck("R12 reload narrow", 1, 2);
    wr(3, 0);
  endtask

  task automatic testFree();
    wr(2, 32'h40);
    wr(0, 1);
    wr(2, 32'h80);
    ticks(1);
    rdCheck("R3 free reaches zero", 1, 0);
    ticks(1);
    rdCheck("R3 free wrap 16", 1, 32'hFFFF);
    ticks(1);
    rdCheck("R3 free counts", 1, 32'hFFFE);
    wr(0, 32'h33);
    rdCheck("R3 load ignored 16", 1, 32'hFFFF);
    rdCheck("R3 load stored", 0, 32'h33);
    wr(2, 32'h82);
    wr(0, 32'h10);
    rdCheck("R3 load ignored 32", 1, 32'hFFFF_FFFF);
    ticks(1);
    rdCheck("R3 free counts 32", 1, 32'hFFFF_FFFE);
    wr(3, 0);
  endtask

  task automatic testPrescale();
    wr(2, 32'h42);
    wr(0, 3);
    wr(2, 32'hC6);
    ticks(10);
    wr(2, 32'hC6);
    ticks(15);
    rdCheck("R2 div16 restart holds", 1, 3);
    ticks(1);
    rdCheck("R2 div16 step", 1, 2);
    ticks(16);
    rdCheck("R2 div16 next step", 1, 1);
    wr(2, 32'h4A);
    wr(0, 3);
    wr(2, 32'hCA);
    ticks(255);
    rdCheck("R2 div256 holds", 1, 3);
    ticks(1);
    rdCheck("R2 div256 step", 1, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadOnlyAndUnmapped();
    testPeriodic();
    testBackground();
    testMask();
    testOneShot();
    testNarrow();
    testFree();
    testPrescale();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule